// File: doc/BRIEF.md
# DMA Multi-Buffer Channel Reload Controller

This block sits beside one DMA channel and decides what the channel's working registers hold at the start of each buffer in a multi-buffer transfer. There are four working registers: source address, destination address, block size and a control word. At every buffer boundary each register is refilled from one of four places. It can keep the value programmed by software, be restored to the value captured when the channel started, continue from the address just past the buffer that finished, or take the matching word of a linked-list descriptor fetched through a valid/ready handshake.

Five configuration bits choose the transfer type, and they give eleven distinct types. They are sampled when the channel starts, so changes made during a transfer have no effect. The controller can hold the channel at a boundary until software acknowledges the buffer-complete event. It ends the transfer with a one-cycle done pulse. The data mover, the bus master, the descriptor memory and arbitration are outside the block.

Top module: `dma_reload_ctl`

## Requirements
- R1: After reset, `busy`, `stalled`, `ll_ready`, `buf_go` and `done` are 0 and all four working registers read 0.
- R2: A `ch_en` pulse while idle loads `usr_src`, `usr_dst`, `usr_size` and `usr_ctrl` into the working registers and into a shadow copy. It also captures the five configuration bits. In the next cycle `busy` and `buf_go` are 1.
- R3: Single-buffer type: `cfg_autoload`=0, `cfg_src_list`=0 and `cfg_dst_list`=0, with the replay bits ignored. The first `buf_done` ends the transfer: `done` is 1 for exactly one cycle after it, `busy` drops, and the registers are not reloaded.
- R4: A field whose source is replay is reloaded with the value captured at start (R2). Between reloads, none of the working registers changes.
- R5: A contiguous address is the previous buffer's start address plus `size << ctrl[1:0]`. Bits 1:0 of the control word encode the transfer width: 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes.
- R6: When a descriptor is needed, `ll_ready` is 1 from the cycle after the boundary (or after the stall is released) until `ll_valid` is seen. The new buffer begins (`buf_go`=1) in the cycle after the handshake, and the descriptor-sourced fields then hold the descriptor's words.
- R7: Source table, for every type except single-buffer. A descriptor is fetched when `cfg_autoload`=0 and either list bit is 1, or when `cfg_autoload`=1 and both list bits are 1. Each address comes from the descriptor when a descriptor is fetched and its own list bit is 1; otherwise from replay if its replay bit is 1, else it is contiguous. Size and control are replayed when `cfg_autoload`=1, and come from the descriptor otherwise.
- R8: At a boundary that is not final, with `irq_unmasked`=1, `stalled` is 1 from the next cycle and stays 1 until `stall_clr`. The working registers do not change while stalled. With `irq_unmasked`=0 the channel does not stall.
- R9: `last_req`=1 together with `buf_done` makes that boundary final, in any type: `done` pulses and no stall occurs, even when `irq_unmasked`=1.
- R10: A descriptor whose `ll_next` is zero marks its buffer as the last one. The `buf_done` that ends that buffer finishes the transfer without `last_req`.
- R11: `ch_en` and changes to the configuration bits while the channel is not idle have no effect on the working registers or on `buf_go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_autoload | input | 1 | Automatic replay of size/control each buffer |
| cfg_src_rep | input | 1 | Source address replays its start value |
| cfg_dst_rep | input | 1 | Destination address replays its start value |
| cfg_src_list | input | 1 | Source address from descriptor |
| cfg_dst_list | input | 1 | Destination address from descriptor |
| ch_en | input | 1 | Start pulse, accepted while idle |
| usr_src | input | AW | Programmed source address |
| usr_dst | input | AW | Programmed destination address |
| usr_size | input | SW | Programmed block size (transfers) |
| usr_ctrl | input | CW | Programmed control word, bits 1:0 width |
| buf_done | input | 1 | Data mover finished the current buffer |
| last_req | input | 1 | Current buffer is the last one |
| irq_unmasked | input | 1 | Buffer-complete interrupt enabled (stall) |
| stall_clr | input | 1 | Software releases a stalled channel |
| ll_valid | input | 1 | Descriptor words valid |
| ll_ready | output | 1 | Controller waiting for a descriptor |
| ll_src | input | AW | Descriptor source address |
| ll_dst | input | AW | Descriptor destination address |
| ll_size | input | SW | Descriptor block size |
| ll_ctrl | input | CW | Descriptor control word |
| ll_next | input | AW | Descriptor next pointer, zero ends the list |
| act_src | output | AW | Working source address |
| act_dst | output | AW | Working destination address |
| act_size | output | SW | Working block size |
| act_ctrl | output | CW | Working control word |
| busy | output | 1 | A buffer is in progress |
| buf_go | output | 1 | One-cycle pulse: new buffer values valid |
| stalled | output | 1 | Channel held at a boundary |
| done | output | 1 | One-cycle pulse: transfer finished |

## Verification
A wrong source choice or bad contiguous arithmetic shows up in the `act_*` values in the `buf_go` cycle of the very next buffer. That is why the bench compares all four fields at every boundary over three buffers of each type. A sequencer that takes the wrong path shows up one cycle after `buf_done`: `stalled`, `ll_ready`, `buf_go` or `done` is wrong there. A lost terminal condition shows up as a missing `done` at the third boundary. Mode bits that are not captured at start are exposed by changing them during a buffer and checking the next reload.

// File: rtl/rld_pkg.sv
package rld_pkg;

  typedef enum logic [1:0] {
    FS_USER   = 2'd0,
    FS_REPLAY = 2'd1,
    FS_CONT   = 2'd2,
    FS_LIST   = 2'd3
  } rld_src_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_STALL = 2'd2,
    ST_FETCH = 2'd3
  } rld_state_e;

  typedef struct packed {
    logic autoload;
    logic src_rep;
    logic dst_rep;
    logic src_list;
    logic dst_list;
  } rld_mode_t;

  typedef struct packed {
    rld_src_e src_sel;
    rld_src_e dst_sel;
    rld_src_e size_sel;
    rld_src_e ctrl_sel;
    logic     single;
    logic     fetch;
  } rld_sel_t;

  // A descriptor is needed in list modes; with autoload it takes both bits.
  function automatic logic needs_list(input rld_mode_t m);
    if (m.autoload) return m.src_list & m.dst_list;
    return m.src_list | m.dst_list;
  endfunction

  function automatic rld_src_e addr_source(input logic fetch, input logic list_bit,
                                           input logic rep_bit);
    if (fetch && list_bit) return FS_LIST;
    if (rep_bit)           return FS_REPLAY;
    return FS_CONT;
  endfunction

endpackage

// File: rtl/rld_mode_decode.sv
module rld_mode_decode
  import rld_pkg::*;
(
  input  rld_mode_t mode,
  output rld_sel_t  sel
);

  logic single_w;
  logic fetch_w;

  assign single_w = !mode.autoload && !mode.src_list && !mode.dst_list;
  assign fetch_w  = needs_list(mode);

  always_comb begin
    sel.single = single_w;
    sel.fetch  = fetch_w;
    if (single_w) begin
      sel.src_sel  = FS_USER;
      sel.dst_sel  = FS_USER;
      sel.size_sel = FS_USER;
      sel.ctrl_sel = FS_USER;
    end else begin
      sel.src_sel  = addr_source(fetch_w, mode.src_list, mode.src_rep);
      sel.dst_sel  = addr_source(fetch_w, mode.dst_list, mode.dst_rep);
      sel.size_sel = mode.autoload ? FS_REPLAY : FS_LIST;
      sel.ctrl_sel = mode.autoload ? FS_REPLAY : FS_LIST;
    end
  end

endmodule

// File: rtl/rld_field.sv
module rld_field
  import rld_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         apply,
  input  rld_src_e     sel,
  input  logic [W-1:0] usr_val,
  input  logic [W-1:0] cont_val,
  input  logic [W-1:0] list_val,
  output logic [W-1:0] act,
  output logic [W-1:0] shadow
);

  logic [W-1:0] reload_val;

  always_comb begin
    unique case (sel)
      FS_USER:   reload_val = usr_val;
      FS_REPLAY: reload_val = shadow;
      FS_CONT:   reload_val = cont_val;
      default:   reload_val = list_val;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act    <= '0;
      shadow <= '0;
    end else if (start) begin
      act    <= usr_val;
      shadow <= usr_val;
    end else if (apply) begin
      act    <= reload_val;
    end
  end

  // R4: a replayed field equals the copy taken at start
  p_replay_shadow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && !start && sel == FS_REPLAY) |=> (act == $past(shadow)));

  // R4: shadow only moves on a start
  p_shadow_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(shadow));

endmodule

// File: rtl/rld_seq.sv
module rld_seq
  import rld_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ch_en,
  input  logic buf_done,
  input  logic last_req,
  input  logic irq_unmasked,
  input  logic stall_clr,
  input  logic ll_valid,
  input  logic ll_next_null,
  input  logic single,
  input  logic fetch,
  output logic start,
  output logic apply,
  output logic busy,
  output logic stalled,
  output logic ll_ready,
  output logic buf_go,
  output logic done
);

  rld_state_e state_q, state_d;
  logic last_flag_q;
  logic boundary, final_buf, leave_hold, apply_plain, apply_list;

  assign start       = (state_q == ST_IDLE) && ch_en;
  assign boundary    = (state_q == ST_RUN) && buf_done;
  assign final_buf   = last_req || single || last_flag_q;
  assign leave_hold  = (boundary && !final_buf && !irq_unmasked) ||
                       ((state_q == ST_STALL) && stall_clr);
  assign apply_plain = leave_hold && !fetch;
  assign apply_list  = (state_q == ST_FETCH) && ll_valid;
  assign apply       = apply_plain || apply_list;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (ch_en) state_d = ST_RUN;
      ST_RUN: begin
        if (buf_done) begin
          if (final_buf)         state_d = ST_IDLE;
          else if (irq_unmasked) state_d = ST_STALL;
          else if (fetch)        state_d = ST_FETCH;
        end
      end
      ST_STALL: if (stall_clr) state_d = fetch ? ST_FETCH : ST_RUN;
      default:  if (ll_valid)  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      last_flag_q <= 1'b0;
      buf_go      <= 1'b0;
      done        <= 1'b0;
    end else begin
      state_q <= state_d;
      buf_go  <= start || apply;
      done    <= boundary && final_buf;
      if (start)           last_flag_q <= 1'b0;
      else if (apply_list) last_flag_q <= ll_next_null;
    end
  end

  assign busy     = (state_q == ST_RUN);
  assign stalled  = (state_q == ST_STALL);
  assign ll_ready = (state_q == ST_FETCH);

  // R3: done only follows a completed buffer
  p_done_after_buf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy && buf_done));

  // R8: a stall is entered only with the interrupt unmasked
  p_stall_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stalled) |-> $past(irq_unmasked && buf_done));

  // R8: stall persists until cleared
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stalled && !stall_clr) |=> stalled);

  // R6: waiting for a descriptor persists until valid
  p_list_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ll_ready && !ll_valid) |=> ll_ready);

  // R2: at most one of run / stall / fetch
  p_one_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, stalled, ll_ready}));

  // R9: a final boundary never stalls
  p_final_no_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && buf_done && last_req) |=> !stalled && done);

endmodule

// File: rtl/dma_reload_ctl.sv
module dma_reload_ctl
  import rld_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_autoload,
  input  logic          cfg_src_rep,
  input  logic          cfg_dst_rep,
  input  logic          cfg_src_list,
  input  logic          cfg_dst_list,
  input  logic          ch_en,
  input  logic [AW-1:0] usr_src,
  input  logic [AW-1:0] usr_dst,
  input  logic [SW-1:0] usr_size,
  input  logic [CW-1:0] usr_ctrl,
  input  logic          buf_done,
  input  logic          last_req,
  input  logic          irq_unmasked,
  input  logic          stall_clr,
  input  logic          ll_valid,
  output logic          ll_ready,
  input  logic [AW-1:0] ll_src,
  input  logic [AW-1:0] ll_dst,
  input  logic [SW-1:0] ll_size,
  input  logic [CW-1:0] ll_ctrl,
  input  logic [AW-1:0] ll_next,
  output logic [AW-1:0] act_src,
  output logic [AW-1:0] act_dst,
  output logic [SW-1:0] act_size,
  output logic [CW-1:0] act_ctrl,
  output logic          busy,
  output logic          buf_go,
  output logic          stalled,
  output logic          done
);

  localparam int WSEL = 2;

  // Start of the next adjacent buffer: base + size scaled by width
  function automatic logic [AW-1:0] next_contig(input logic [AW-1:0] base,
                                                input logic [SW-1:0] count,
                                                input logic [WSEL-1:0] wsel);
    return base + (AW'(count) << wsel);
  endfunction

  rld_mode_t mode_q, mode_in;
  rld_sel_t  sel;
  logic      start, apply;
  logic [AW-1:0] cont_src, cont_dst;
  logic [AW-1:0] shd_src, shd_dst;
  logic [SW-1:0] shd_size;
  logic [CW-1:0] shd_ctrl;

  assign mode_in = '{autoload: cfg_autoload, src_rep: cfg_src_rep, dst_rep: cfg_dst_rep,
                     src_list: cfg_src_list, dst_list: cfg_dst_list};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= '0;
    else if (start) mode_q <= mode_in;
  end

  rld_mode_decode u_dec (
    .mode (mode_q),
    .sel  (sel)
  );

  rld_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .ch_en        (ch_en),
    .buf_done     (buf_done),
    .last_req     (last_req),
    .irq_unmasked (irq_unmasked),
    .stall_clr    (stall_clr),
    .ll_valid     (ll_valid),
    .ll_next_null (ll_next == '0),
    .single       (sel.single),
    .fetch        (sel.fetch),
    .start        (start),
    .apply        (apply),
    .busy         (busy),
    .stalled      (stalled),
    .ll_ready     (ll_ready),
    .buf_go       (buf_go),
    .done         (done)
  );

  assign cont_src = next_contig(act_src, act_size, act_ctrl[WSEL-1:0]);
  assign cont_dst = next_contig(act_dst, act_size, act_ctrl[WSEL-1:0]);

  rld_field #(.W(AW)) u_src (
    .clk (clk), .rst_n (rst_n), .start (start), .apply (apply), .sel (sel.src_sel),
    .usr_val (usr_src), .cont_val (cont_src), .list_val (ll_src),
    .act (act_src), .shadow (shd_src)
  );

  rld_field #(.W(AW)) u_dst (
    .clk (clk), .rst_n (rst_n), .start (start), .apply (apply), .sel (sel.dst_sel),
    .usr_val (usr_dst), .cont_val (cont_dst), .list_val (ll_dst),
    .act (act_dst), .shadow (shd_dst)
  );

  rld_field #(.W(SW)) u_size (
    .clk (clk), .rst_n (rst_n), .start (start), .apply (apply), .sel (sel.size_sel),
    .usr_val (usr_size), .cont_val (act_size), .list_val (ll_size),
    .act (act_size), .shadow (shd_size)
  );

  rld_field #(.W(CW)) u_ctrl (
    .clk (clk), .rst_n (rst_n), .start (start), .apply (apply), .sel (sel.ctrl_sel),
    .usr_val (usr_ctrl), .cont_val (act_ctrl), .list_val (ll_ctrl),
    .act (act_ctrl), .shadow (shd_ctrl)
  );

  // R4: working registers only change on a buffer start
  p_regs_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_go |-> $stable({act_src, act_dst, act_size, act_ctrl}));

  // R7: descriptor requested only in list-fed types
  p_list_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ll_ready |-> (mode_q.src_list || mode_q.dst_list));

  // R11: configuration frozen while the channel is active
  p_mode_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || stalled || ll_ready) |=> $stable(mode_q));

  // R3: single-buffer type never reloads
  p_single_no_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.single && (busy || stalled)) |=> !buf_go);

endmodule

// File: tb/tb_dma_reload_ctl.sv
module tb_dma_reload_ctl;

  localparam int AW = 32;
  localparam int SW = 16;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_autoload = 0, cfg_src_rep = 0, cfg_dst_rep = 0, cfg_src_list = 0, cfg_dst_list = 0;
  logic ch_en = 0, buf_done = 0, last_req = 0, irq_unmasked = 0, stall_clr = 0, ll_valid = 0;
  logic [AW-1:0] usr_src = '0, usr_dst = '0, ll_src = '0, ll_dst = '0, ll_next = '0;
  logic [SW-1:0] usr_size = '0, ll_size = '0;
  logic [CW-1:0] usr_ctrl = '0, ll_ctrl = '0;
  logic          ll_ready, busy, buf_go, stalled, done;
  logic [AW-1:0] act_src, act_dst;
  logic [SW-1:0] act_size;
  logic [CW-1:0] act_ctrl;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #2.5ns clk = ~clk;

  dma_reload_ctl #(.AW(AW), .SW(SW), .CW(CW)) dut (
    .clk, .rst_n, .cfg_autoload, .cfg_src_rep, .cfg_dst_rep, .cfg_src_list, .cfg_dst_list,
    .ch_en, .usr_src, .usr_dst, .usr_size, .usr_ctrl, .buf_done, .last_req,
    .irq_unmasked, .stall_clr, .ll_valid, .ll_ready, .ll_src, .ll_dst, .ll_size,
    .ll_ctrl, .ll_next, .act_src, .act_dst, .act_size, .act_ctrl, .busy, .buf_go,
    .stalled, .done
  );

  task automatic chk(input string req, input logic [63:0] actual, input logic [63:0] expect_v);
    n_chk++;
    if (actual !== expect_v) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expect_v);
    end
  endtask

  // 0 user, 1 replay, 2 contiguous, 3 descriptor
  function automatic int kind_addr(input logic [4:0] m, input bit is_src);
    bit lst = is_src ? m[1] : m[0];
    bit rep = is_src ? m[3] : m[2];
    bit fetching = m[4] ? (m[1] && m[0]) : (m[1] || m[0]);
    if (fetching && lst) return 3;
    return rep ? 1 : 2;
  endfunction

  function automatic logic [AW-1:0] exp_bytes(input logic [1:0] w);
    case (w)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 4;
      default: return 8;
    endcase
  endfunction

  // mode bits {autoload, src_rep, dst_rep, src_list, dst_list}
  function automatic logic [4:0] mode_row(input int i);
    logic [1:0] rr = 2'($urandom);
    case (i)
      0:  return {1'b0, rr, 2'b00};
      1:  return {1'b0, rr, 2'b11};
      2:  return 5'b00010;
      3:  return 5'b00110;
      4:  return 5'b00001;
      5:  return 5'b01001;
      6:  return 5'b10000;
      7:  return 5'b11000;
      8:  return 5'b10100;
      9:  return 5'b11100;
      default: return {1'b1, rr, 2'b11};
    endcase
  endfunction

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_row(input int row, input bit irq);
    logic [4:0] m = mode_row(row);
    bit single_t = (m[4:0] & 5'b10011) == 5'b00000;
    bit fetching = m[4] ? (m[1] && m[0]) : (m[1] || m[0]);
    logic [AW-1:0] i_src, i_dst, e_src, e_dst;
    logic [SW-1:0] i_size, e_size;
    logic [CW-1:0] i_ctrl, e_ctrl;
    string tag;
    {cfg_autoload, cfg_src_rep, cfg_dst_rep, cfg_src_list, cfg_dst_list} = m;
    irq_unmasked = irq;
    i_src = $urandom; i_dst = $urandom;
    i_size = SW'($urandom_range(1, 300)); i_ctrl = CW'($urandom);
    usr_src = i_src; usr_dst = i_dst; usr_size = i_size; usr_ctrl = i_ctrl;
    ch_en = 1; tick; ch_en = 0;
    chk($sformatf("R2 row%0d go", row), {busy, buf_go}, 2'b11);
    chk("R2 src", act_src, i_src);
    chk("R2 dst", act_dst, i_dst);
    chk("R2 size/ctrl", {act_size, act_ctrl}, {i_size, i_ctrl});
    e_src = i_src; e_dst = i_dst; e_size = i_size; e_ctrl = i_ctrl;
    // R11: restart attempt and config change mid-buffer are ignored
    usr_src = ~i_src; usr_dst = ~i_dst;
    {cfg_autoload, cfg_src_rep, cfg_dst_rep, cfg_src_list, cfg_dst_list} = ~m;
    ch_en = 1; tick; ch_en = 0;
    chk("R11 no restart", {buf_go, busy}, 2'b01);
    chk("R11 regs kept", {act_src, act_dst}, {e_src, e_dst});
    for (int b = 0; b < 3; b++) begin
      bit fin = single_t || b == 2;
      logic [AW-1:0] n_src, n_dst, d_src, d_dst;
      logic [SW-1:0] n_size, d_size;
      logic [CW-1:0] n_ctrl, d_ctrl;
      tag = $sformatf("row%0d buf%0d", row, b);
      repeat ($urandom_range(0, 2)) tick;
      buf_done = 1;
      last_req = fin && !single_t && !fetching;
      tick;
      buf_done = 0; last_req = 0;
      if (fin) begin
        chk({"R3/R9/R10 done ", tag}, {done, busy, stalled}, 3'b100);
        tick;
        chk({"R3 done pulse ", tag}, {done, busy}, 2'b00);
        break;
      end
      chk({"R8 stall ", tag}, stalled, irq);
      if (irq) begin
        repeat ($urandom_range(1, 3)) tick;
        chk({"R8 held ", tag}, {stalled, buf_go}, 2'b10);
        chk({"R8 frozen ", tag}, {act_src, act_dst}, {e_src, e_dst});
        stall_clr = 1; tick; stall_clr = 0;
      end
      d_src = $urandom; d_dst = $urandom;
      d_size = SW'($urandom_range(1, 300)); d_ctrl = CW'($urandom);
      if (fetching) begin
        chk({"R6 ready ", tag}, {ll_ready, buf_go}, 2'b10);
        repeat ($urandom_range(0, 2)) tick;
        chk({"R6 waiting ", tag}, ll_ready, 1'b1);
        ll_src = d_src; ll_dst = d_dst; ll_size = d_size; ll_ctrl = d_ctrl;
        ll_next = (b == 1) ? '0 : (AW'($urandom) | 32'h4);
        ll_valid = 1; tick; ll_valid = 0;
      end
      case (kind_addr(m, 1))
        1: n_src = i_src;
        2: n_src = e_src + AW'(e_size) * exp_bytes(e_ctrl[1:0]);
        default: n_src = d_src;
      endcase
      case (kind_addr(m, 0))
        1: n_dst = i_dst;
        2: n_dst = e_dst + AW'(e_size) * exp_bytes(e_ctrl[1:0]);
        default: n_dst = d_dst;
      endcase
      n_size = m[4] ? i_size : d_size;
      n_ctrl = m[4] ? i_ctrl : d_ctrl;
      chk({"R6 go ", tag}, {buf_go, busy, ll_ready}, 3'b110);
      chk({"R7/R5/R4 src ", tag}, act_src, n_src);
      chk({"R7/R5/R4 dst ", tag}, act_dst, n_dst);
      chk({"R7/R4 size ctrl ", tag}, {act_size, act_ctrl}, {n_size, n_ctrl});
      e_src = n_src; e_dst = n_dst; e_size = n_size; e_ctrl = n_ctrl;
    end
    tick;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset flags", {busy, stalled, ll_ready, buf_go, done}, 5'b0);
    chk("R1 reset regs", {act_src, act_dst}, 64'd0);
    chk("R1 reset size ctrl", {act_size, act_ctrl}, 32'd0);
    rst_n = 1;
    tick;
    chk("R1 idle", {busy, buf_go}, 2'b00);
    for (int r = 0; r < 11; r++) begin
      run_row(r, 1'b0);
      run_row(r, 1'b1);
    end
    for (int k = 0; k < 30; k++) run_row(int'($urandom_range(0, 10)), 1'($urandom));
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule